// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the transmit data line of a CAN controller and the enable of a bus driver. It measures how long the transmit input has been dominant (logic 0) without a break. When that run grows longer than a programmed limit, the guard turns the driver off so that the bus falls back to recessive. This stops a stuck controller or a broken wire from holding the whole bus dominant. After it has tripped, the guard keeps the driver off for as long as the transmit input stays low. It re-arms only when the input has gone back to recessive.

A standby input turns the driver off and leaves the bus recessive. When standby is released, a separate wake-up delay must run out before the driver may be enabled again. The timeout is a value in clock cycles given on an input port. It is clamped into a window that is set by parameters; for the nominal timeout the default window spans roughly 300 to 700 µs at 250 MHz. Both asynchronous inputs pass through a two-flop synchronizer before they are used. The driver data output is dominant only while the driver is enabled.

Top module: `tx_dom_guard`

## Requirements
- R1: Let T be the effective timeout. Suppose `txd_i` is sampled 0 (dominant) on T+1 consecutive rising edges, and the (T+1)th of these is edge n. Then `fault_o` reads 1 after edge n+2, and `drv_en_o` reads 0 with `drv_data_o` at 1 (recessive) from edge n+3 on.
- R2: A dominant run of exactly T sampled edges never sets `fault_o`. This covers the longest legal frame run of eleven dominant bits when the bit period is at most T/11 cycles.
- R3: While `fault_o` is 1 and `txd_i` stays 0, `fault_o` stays 1, `drv_en_o` stays 0 and `drv_data_o` stays 1. A long run of low samples never re-triggers the fault and never clears it.
- R4: Let edge r be the first edge that samples `txd_i` as 1 after a fault. Then `fault_o` reads 0 after edge r+2 and `drv_en_o` reads 1 again after edge r+3, provided standby is not set. Later dominant input is driven again.
- R5: The effective timeout T equals `timeout_i` clamped into the range [TMO_MIN, TMO_MAX].
- R6: While the driver is enabled, a `txd_i` value sampled at edge k appears on `drv_data_o` after edge k+2. Whenever `drv_en_o` is 0, `drv_data_o` is 1.
- R7: If `standby_i` (1 = standby) is sampled 1 at edge k, `drv_en_o` reads 0 after edge k+2. During standby `drv_data_o` stays 1 whatever `txd_i` does.
- R8: If `standby_i` is sampled 0 at edge k after standby, `drv_en_o` stays 0 up to edge k+WAKE_CYC+1 and reads 1 after edge k+WAKE_CYC+2, provided no fault is present.
- R9: A fault stays set through a standby period. After standby ends it is released only by `txd_i` returning to 1, as in R4.
- R10: While `rst_n` is low, `drv_en_o` reads 0, `drv_data_o` reads 1 and `fault_o` reads 0. After reset the wake-up delay has to run out before the driver is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txd_i | input | 1 | Transmit data from the controller, 0 = dominant |
| standby_i | input | 1 | Standby request, 1 = standby |
| timeout_i | input | CNT_W | Dominant timeout in clock cycles, clamped to [TMO_MIN, TMO_MAX] |
| drv_en_o | output | 1 | Driver enable, 1 = driving |
| drv_data_o | output | 1 | Data to the driver, 1 (recessive) whenever disabled |
| fault_o | output | 1 | Dominant timeout fault flag |

## Verification
The assertions check on every cycle the rules that must always hold. A disabled driver never sends dominant data. A fault only ever rises after a dominant sample. The fault stays set while the input is low and clears on a recessive sample. Standby always turns the driver off, the enable only rises after standby has been low for a while, and the run counter saturates instead of wrapping. Some behaviour depends on exact cycle counts, and only the bench scenarios can show it. These are the trip point at T versus T+1 dominant samples, the clamping of the timeout value, the length of the wake-up delay, the data latency, and re-arming after release, including release of a fault that was held through standby.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
    localparam logic LVL_DOM = 1'b0;
    localparam logic LVL_REC = 1'b1;

    typedef struct packed {
        logic en;
        logic data;
    } drv_out_t;
endpackage

// File: rtl/tdg_sync.sv
module tdg_sync #(
    parameter int WIDTH   = 2,
    parameter int STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/tdg_dom_timer.sv
module tdg_dom_timer
    import tdg_pkg::*;
#(
    parameter int CNT_W   = 18,
    parameter int TMO_MIN = 75000,
    parameter int TMO_MAX = 175000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txd_s,
    input  logic [CNT_W-1:0] timeout_i,
    output logic             fault_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(TMO_MIN);
    localparam logic [CNT_W-1:0] MAX_V = CNT_W'(TMO_MAX);
    localparam logic [CNT_W-1:0] SAT_V = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fault;
    } tmr_t;

    tmr_t             st_d, st_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        if (timeout_i < MIN_V)      limit = MIN_V;
        else if (timeout_i > MAX_V) limit = MAX_V;
        else                        limit = timeout_i;

        st_d = st_q;
        if (txd_s == LVL_REC) begin
            st_d.cnt   = '0;
            st_d.fault = 1'b0;
        end else begin
            if (st_q.cnt != SAT_V) st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt >= limit) st_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault_o = st_q.fault;
    assign cnt_o   = st_q.cnt;
endmodule

// File: rtl/tdg_wake_timer.sv
module tdg_wake_timer #(
    parameter int WAKE_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stby_s,
    output logic ready_o
);
    localparam int WK_W = $clog2(WAKE_CYC + 1);
    localparam logic [WK_W-1:0] LAST_V = WK_W'(WAKE_CYC - 1);

    typedef struct packed {
        logic [WK_W-1:0] cnt;
        logic            ready;
    } wake_t;

    wake_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stby_s) begin
            st_d.cnt   = '0;
            st_d.ready = 1'b0;
        end else if (!st_q.ready) begin
            if (st_q.cnt == LAST_V) st_d.ready = 1'b1;
            else                    st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o = st_q.ready;
endmodule

// File: rtl/tx_dom_guard.sv
module tx_dom_guard
    import tdg_pkg::*;
#(
    parameter int CNT_W       = 18,
    parameter int TMO_MIN     = 75000,
    parameter int TMO_MAX     = 175000,
    parameter int WAKE_CYC    = 2500,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txd_i,
    input  logic             standby_i,
    input  logic [CNT_W-1:0] timeout_i,
    output logic             drv_en_o,
    output logic             drv_data_o,
    output logic             fault_o
);
    logic [1:0]       sync_out;
    logic             txd_s, stby_s, wake_ready;
    logic [CNT_W-1:0] dom_cnt;
    drv_out_t         out_d, out_q;

    tdg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({standby_i, txd_i}),
        .sync_o  (sync_out)
    );

    assign txd_s  = sync_out[0];
    assign stby_s = sync_out[1];

    tdg_dom_timer #(.CNT_W(CNT_W), .TMO_MIN(TMO_MIN), .TMO_MAX(TMO_MAX)) u_dom (
        .clk       (clk),
        .rst_n     (rst_n),
        .txd_s     (txd_s),
        .timeout_i (timeout_i),
        .fault_o   (fault_o),
        .cnt_o     (dom_cnt)
    );

    tdg_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .stby_s  (stby_s),
        .ready_o (wake_ready)
    );

    always_comb begin
        out_d.en   = !stby_s && wake_ready && !fault_o;
        out_d.data = out_d.en ? txd_s : LVL_REC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{en: 1'b0, data: LVL_REC};
        else        out_q <= out_d;
    end

    assign drv_en_o   = out_q.en;
    assign drv_data_o = out_q.data;
endmodule

// File: rtl/tdg_checker.sv
module tdg_checker #(
    parameter int CNT_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txd_s,
    input logic             stby_s,
    input logic             fault,
    input logic             en,
    input logic             data,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] SAT_V = '1;

    AST_NO_DOM_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> data);                                                   // R6
    AST_FAULT_AFTER_DOM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(!txd_s));                                 // R1
    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !en);                                                  // R1
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !txd_s) |=> fault);                                    // R3
    AST_FAULT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        txd_s |=> !fault);                                               // R4
    AST_STBY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        stby_s |=> !en);                                                 // R7
    AST_WAKE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> ($past(!stby_s) && $past(!stby_s, 2)));            // R8
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == SAT_V) |=> (cnt == SAT_V || cnt == '0));                 // R3
endmodule

bind tx_dom_guard tdg_checker #(.CNT_W(CNT_W)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .txd_s  (txd_s),
    .stby_s (stby_s),
    .fault  (fault_o),
    .en     (drv_en_o),
    .data   (drv_data_o),
    .cnt    (dom_cnt)
);

// File: tb/test_tx_dom_guard.sv
module test_tx_dom_guard;
    localparam int CNT_W = 8;
    localparam int TMIN  = 8;
    localparam int TMAX  = 40;
    localparam int WAKE  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd = 1'b1;
    logic stby = 1'b0;
    logic [CNT_W-1:0] tmo = 8'd20;
    logic en, data, fault;

    int cyc = 0;
    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        int    sig;
        logic  val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tx_dom_guard #(.CNT_W(CNT_W), .TMO_MIN(TMIN), .TMO_MAX(TMAX), .WAKE_CYC(WAKE)) i_tx_dom_guard (
        .clk(clk), .rst_n(rst_n), .txd_i(txd), .standby_i(stby), .timeout_i(tmo),
        .drv_en_o(en), .drv_data_o(data), .fault_o(fault)
    );

    function automatic string sname(int s);
        return (s == 0) ? "drv_en_o" : (s == 1) ? "drv_data_o" : "fault_o";
    endfunction

    task automatic chk(string tag, string nm, logic act, logic expv);
        nvec++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s cycle %0d %s: actual %0b expected %0b", tag, cyc, nm, act, expv);
        end
    endtask

    task automatic push(int at, int sig, logic v, string tag);
        exp_t e;
        e.at = at; e.sig = sig; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares due scoreboard items between clock edges
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at <= cyc) begin
                logic a;
                case (sb[i].sig)
                    0:       a = en;
                    1:       a = data;
                    default: a = fault;
                endcase
                if (sb[i].at < cyc) chk(sb[i].tag, "missed", 1'b1, 1'b0);
                else                chk(sb[i].tag, sname(sb[i].sig), a, sb[i].val);
                sb.delete(i);
            end
        end
    end

    // k returns the rising edge that first samples the new value
    task automatic set_txd(logic v, output int k);
        @(negedge clk);
        txd = v;
        k = cyc + 1;
    endtask

    task automatic set_stby(logic v, output int k);
        @(negedge clk);
        stby = v;
        k = cyc + 1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic v);
        int k;
        set_txd(v, k);
        push(k + 2, 2, 1'b0, "R2");
        idle(1);
    endtask

    initial begin
        int k, r, ks, kr;
        idle(3);
        chk("R10", "drv_en_o", en, 1'b0);
        chk("R10", "drv_data_o", data, 1'b1);
        chk("R10", "fault_o", fault, 1'b0);
        rst_n = 1'b1;
        push(cyc + 2, 0, 1'b0, "R10");
        push(cyc + 20, 0, 1'b1, "R10");
        idle(25);

        // R6 data path, R1 trip, R3 hold, R4 release and re-arm (T = 20)
        set_txd(1'b0, k);
        push(k + 1, 1, 1'b1, "R6");
        push(k + 2, 1, 1'b0, "R6");
        push(k + 2, 0, 1'b1, "R6");
        push(k + 21, 2, 1'b0, "R1");
        push(k + 22, 2, 1'b1, "R1");
        push(k + 22, 0, 1'b1, "R1");
        push(k + 23, 0, 1'b0, "R1");
        push(k + 23, 1, 1'b1, "R1");
        idle(38);
        push(k + 38, 2, 1'b1, "R3");
        push(k + 38, 0, 1'b0, "R3");
        push(k + 38, 1, 1'b1, "R3");
        set_txd(1'b1, r);
        push(r + 1, 2, 1'b1, "R4");
        push(r + 2, 2, 1'b0, "R4");
        push(r + 2, 0, 1'b0, "R4");
        push(r + 3, 0, 1'b1, "R4");
        idle(5);
        set_txd(1'b0, k);
        push(k + 2, 1, 1'b0, "R4");
        push(k + 2, 0, 1'b1, "R4");
        idle(3);
        set_txd(1'b1, r);
        idle(5);

        // R2: exactly T dominant samples
        set_txd(1'b0, k);
        idle(19);
        set_txd(1'b1, r);
        push(k + 21, 1, 1'b0, "R2");
        push(k + 22, 1, 1'b1, "R2");
        push(k + 21, 2, 1'b0, "R2");
        push(k + 22, 2, 1'b0, "R2");
        push(k + 23, 2, 1'b0, "R2");
        idle(5);

        // R2: frame-like stream, bit period 2 cycles, T = 22
        tmo = 8'd22;
        send_bit(1'b1);
        for (int i = 0; i < 11; i++) send_bit(1'b0);
        send_bit(1'b1);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        for (int i = 0; i < 11; i++) send_bit(1'b0);
        send_bit(1'b1);
        push(cyc + 3, 2, 1'b0, "R2");
        push(cyc + 3, 0, 1'b1, "R2");
        idle(5);

        // R5: value below the window clamps to TMIN
        tmo = 8'd2;
        set_txd(1'b0, k);
        push(k + TMIN + 1, 2, 1'b0, "R5");
        push(k + TMIN + 2, 2, 1'b1, "R5");
        idle(12);
        set_txd(1'b1, r);
        push(r + 2, 2, 1'b0, "R5");
        idle(5);
        // R5: value above the window clamps to TMAX
        tmo = 8'd200;
        set_txd(1'b0, k);
        push(k + TMAX + 1, 2, 1'b0, "R5");
        push(k + TMAX + 2, 2, 1'b1, "R5");
        idle(44);
        set_txd(1'b1, r);
        push(r + 2, 2, 1'b0, "R5");
        push(r + 3, 0, 1'b1, "R5");
        idle(5);
        tmo = 8'd20;

        // R7 standby entry, txd ignored; R8 wake delay
        set_stby(1'b1, ks);
        push(ks + 1, 0, 1'b1, "R7");
        push(ks + 2, 0, 1'b0, "R7");
        push(ks + 2, 1, 1'b1, "R7");
        idle(3);
        set_txd(1'b0, k);
        push(k + 2, 1, 1'b1, "R7");
        push(k + 3, 1, 1'b1, "R7");
        push(k + 3, 0, 1'b0, "R7");
        idle(3);
        set_txd(1'b1, r);
        idle(2);
        set_stby(1'b0, kr);
        push(kr + WAKE + 1, 0, 1'b0, "R8");
        push(kr + WAKE + 2, 0, 1'b1, "R8");
        idle(WAKE + 5);

        // R9: fault kept across standby
        set_txd(1'b0, k);
        push(k + 22, 2, 1'b1, "R9");
        idle(24);
        set_stby(1'b1, ks);
        idle(8);
        set_stby(1'b0, kr);
        idle(WAKE + 6);
        push(cyc + 1, 2, 1'b1, "R9");
        push(cyc + 1, 0, 1'b0, "R9");
        set_txd(1'b1, r);
        push(r + 1, 2, 1'b1, "R9");
        push(r + 2, 2, 1'b0, "R9");
        push(r + 3, 0, 1'b1, "R9");
        idle(10);

        foreach (sb[i]) chk(sb[i].tag, "unchecked", 1'b1, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nvec++;
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule